// File: doc/BRIEF.md
# Buck Gate-Drive Override Sequencer

This block sits between a PWM modulator and the two gate-driver enables of a synchronous buck power stage. In ordinary operation it passes the PWM demand through as complementary drive: high-side on when the modulator asks for a pulse, low-side on otherwise. It steps in with two override behaviours. The first is an overvoltage response, which is latched. The second is a braking mode that is entered when the modulator skips a pulse during a load step-down.

When the overvoltage comparator flag is raised, the block parks the high-side switch and turns the low-side switch on to sink the output. The low-side switch stays on for as long as the flag is high. Once the flag drops, both switches are held off in a latched state. Only the reset input, driven by power or enable cycling, clears that latch, although a fresh overvoltage event re-enters the sinking phase. When the modulator reports a skipped (zero-duty) pulse on a switching-cycle tick, the block turns both switches off, so that the inductor current decays through the low-side body diode. Braking is blocked while pre-bias start-up is active, and the overvoltage sequence always takes precedence over it.

The block holds four states in a one-hot register:

- NORMAL: complementary drive.
- BRAKE: both switches off.
- OV_SINK: low-side switch on.
- OV_HOLD: both switches off, latched.

The transitions are:

- NORMAL→BRAKE on brake entry.
- BRAKE→NORMAL on brake exit.
- NORMAL/BRAKE→OV_SINK on the overvoltage flag.
- OV_SINK→OV_HOLD when the flag drops.
- OV_HOLD→OV_SINK on a new overvoltage event.
- Any state→NORMAL on reset.

Top module: `drive_override`

## Requirements
- R1: While `rst_n` is low, both `hs_en` and `ls_en` are low.
- R2: In NORMAL, after each clock edge `hs_en` equals the `pwm_req` sampled at that edge and `ls_en` equals its inverse.
- R3: If `ov_flag` is high at an edge, then after that edge `hs_en` is 0 and `ls_en` is 1, whatever the current state and other inputs are.
- R4: In OV_SINK, `ls_en` stays 1 while `ov_flag` stays high. The first edge that sees `ov_flag` low moves to OV_HOLD, and both enables read 0 after it.
- R5: In OV_HOLD, both enables stay 0 whatever `pwm_req`, `skip_pulse`, `cyc_tick` and `prebias_act` do, as long as `ov_flag` is low.
- R6: In OV_HOLD, `ov_flag` high at an edge returns the block to OV_SINK, so `ls_en` reads 1 after that edge.
- R7: In NORMAL, an edge with `cyc_tick`=1, `skip_pulse`=1 and `prebias_act`=0 enters BRAKE, and both enables read 0 after it. `skip_pulse` without `cyc_tick` has no effect.
- R8: With `prebias_act` high, a skip event does not enter BRAKE. If `prebias_act` is high at an edge while in BRAKE, the block returns to NORMAL and drives from `pwm_req` at that edge.
- R9: In BRAKE, the first edge with `cyc_tick`=1 and `skip_pulse`=0 returns to NORMAL, and the enables follow `pwm_req` at that edge. Until then both enables stay 0.
- R10: `ov_flag` overrides braking. From BRAKE, or from NORMAL with a simultaneous skip event, `ov_flag` high gives `ls_en`=1 and `hs_en`=0.
- R11: `hs_en` and `ls_en` are never both 1.
- R12: The state register is one-hot at all times. Pulsing `rst_n` from OV_HOLD restores NORMAL drive from the first edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset from power/enable cycling |
| pwm_req | input | 1 | Modulator demand: 1 = high-side on |
| skip_pulse | input | 1 | Modulator requests zero duty this switching cycle |
| ov_flag | input | 1 | Overvoltage comparator output |
| prebias_act | input | 1 | Pre-bias start-up in progress |
| cyc_tick | input | 1 | One-clock strobe at each switching-cycle boundary |
| hs_en | output | 1 | High-side driver enable |
| ls_en | output | 1 | Low-side driver enable |

## Verification
Every result of this block appears exactly one clock edge after the inputs that cause it. The next state and both enables are captured together at that edge from the inputs present there. The bench therefore changes inputs just after a rising edge and samples the enables one nanosecond after the following rising edge. It compares them against the drive pattern the requirements give for the state that edge should reach. Sequences that span several states, such as sink to hold, re-trip, braking entry and exit, and reset out of hold, are stepped one edge at a time with a check after each edge.

// File: rtl/drive_override_pkg.sv
package drive_override_pkg;

    localparam int NUM_STATES = 4;

    typedef enum logic [NUM_STATES-1:0] {
        ST_NORMAL  = 4'b0001,
        ST_BRAKE   = 4'b0010,
        ST_OV_SINK = 4'b0100,
        ST_OV_HOLD = 4'b1000
    } ovr_state_t;

    typedef struct packed {
        logic hs;
        logic ls;
    } drive_pair_t;

endpackage

// File: rtl/drive_override_qual.sv
module drive_override_qual (
    input  logic skip_pulse,
    input  logic prebias_act,
    input  logic cyc_tick,
    output logic brake_enter,
    output logic brake_leave
);
    // A skip only counts on a cycle boundary and never during pre-bias.
    always_comb begin
        brake_enter = cyc_tick & skip_pulse & ~prebias_act;
        brake_leave = prebias_act | (cyc_tick & ~skip_pulse);
    end
endmodule

// File: rtl/drive_override_fsm.sv
module drive_override_fsm
    import drive_override_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ov_flag,
    input  logic       brake_enter,
    input  logic       brake_leave,
    output ovr_state_t state_q,
    output ovr_state_t state_d
);
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NORMAL: begin
                if (ov_flag)          state_d = ST_OV_SINK;
                else if (brake_enter) state_d = ST_BRAKE;
                else                  state_d = ST_NORMAL;
            end
            ST_BRAKE: begin
                if (ov_flag)          state_d = ST_OV_SINK;
                else if (brake_leave) state_d = ST_NORMAL;
                else                  state_d = ST_BRAKE;
            end
            ST_OV_SINK: begin
                if (ov_flag) state_d = ST_OV_SINK;
                else         state_d = ST_OV_HOLD;
            end
            ST_OV_HOLD: begin
                if (ov_flag) state_d = ST_OV_SINK;
                else         state_d = ST_OV_HOLD;
            end
            default: state_d = ST_OV_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_NORMAL;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/drive_override_out.sv
module drive_override_out
    import drive_override_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  ovr_state_t state_d,
    input  logic       pwm_req,
    output logic       hs_en,
    output logic       ls_en
);
    drive_pair_t pair_d;
    drive_pair_t pair_q;

    always_comb begin
        pair_d = '0;
        unique case (state_d)
            ST_NORMAL:  pair_d = '{hs: pwm_req, ls: ~pwm_req};
            ST_BRAKE:   pair_d = '{hs: 1'b0, ls: 1'b0};
            ST_OV_SINK: pair_d = '{hs: 1'b0, ls: 1'b1};
            ST_OV_HOLD: pair_d = '{hs: 1'b0, ls: 1'b0};
            default:    pair_d = '{hs: 1'b0, ls: 1'b0};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pair_q <= '0;
        else        pair_q <= pair_d;
    end

    assign hs_en = pair_q.hs;
    assign ls_en = pair_q.ls;
endmodule

// File: rtl/drive_override.sv
module drive_override
    import drive_override_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_req,
    input  logic skip_pulse,
    input  logic ov_flag,
    input  logic prebias_act,
    input  logic cyc_tick,
    output logic hs_en,
    output logic ls_en
);
    logic       brake_enter;
    logic       brake_leave;
    ovr_state_t state_q;
    ovr_state_t state_d;

    drive_override_qual qual_i (
        .skip_pulse (skip_pulse),
        .prebias_act(prebias_act),
        .cyc_tick   (cyc_tick),
        .brake_enter(brake_enter),
        .brake_leave(brake_leave)
    );

    drive_override_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ov_flag    (ov_flag),
        .brake_enter(brake_enter),
        .brake_leave(brake_leave),
        .state_q    (state_q),
        .state_d    (state_d)
    );

    drive_override_out out_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .state_d(state_d),
        .pwm_req(pwm_req),
        .hs_en  (hs_en),
        .ls_en  (ls_en)
    );
endmodule

// File: rtl/drive_override_chk.sv
module drive_override_chk
    import drive_override_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       pwm_req,
    input logic       skip_pulse,
    input logic       ov_flag,
    input logic       prebias_act,
    input logic       cyc_tick,
    input logic       hs_en,
    input logic       ls_en,
    input ovr_state_t st
);
    // R11
    no_shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en));

    // R12
    state_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st) == 1);

    // R3
    ov_sinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ov_flag |=> (ls_en && !hs_en));

    // R4
    sink_to_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OV_SINK && !ov_flag) |=> (!hs_en && !ls_en && st == ST_OV_HOLD));

    // R5
    hold_stays_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OV_HOLD && !ov_flag) |=> (!hs_en && !ls_en));

    // R7
    brake_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_NORMAL && cyc_tick && skip_pulse && !prebias_act && !ov_flag)
            |=> (!hs_en && !ls_en));

    // R9
    brake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BRAKE && cyc_tick && !skip_pulse && !ov_flag)
            |=> (hs_en == $past(pwm_req) && ls_en == !$past(pwm_req)));

    // R2
    normal_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_NORMAL && !ov_flag && !(cyc_tick && skip_pulse && !prebias_act))
            |=> (hs_en == $past(pwm_req) && ls_en == !$past(pwm_req)));
endmodule

bind drive_override drive_override_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwm_req    (pwm_req),
    .skip_pulse (skip_pulse),
    .ov_flag    (ov_flag),
    .prebias_act(prebias_act),
    .cyc_tick   (cyc_tick),
    .hs_en      (hs_en),
    .ls_en      (ls_en),
    .st         (state_q)
);

// File: tb/drive_override_tb_top.sv
`timescale 1ns/1ps
module drive_override_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_req = 1'b0, skip_pulse = 1'b0, ov_flag = 1'b0;
    logic prebias_act = 1'b0, cyc_tick = 1'b0;
    logic hs_en, ls_en;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    drive_override dut_i (
        .clk(clk), .rst_n(rst_n), .pwm_req(pwm_req), .skip_pulse(skip_pulse),
        .ov_flag(ov_flag), .prebias_act(prebias_act), .cyc_tick(cyc_tick),
        .hs_en(hs_en), .ls_en(ls_en)
    );

    task automatic chk(input string req, input logic eh, input logic el);
        total++;
        if (hs_en !== eh || ls_en !== el) begin
            bad++;
            $display("FAIL %s: hs/ls got %b%b expected %b%b", req, hs_en, ls_en, eh, el);
        end
        total++;
        if (hs_en === 1'b1 && ls_en === 1'b1) begin
            bad++;
            $display("FAIL R11: hs/ls got 11 expected not both high");
        end
    endtask

    task automatic set_in(input logic p, input logic s, input logic o,
                          input logic b, input logic t);
        pwm_req = p; skip_pulse = s; ov_flag = o; prebias_act = b; cyc_tick = t;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        set_in(0, 0, 0, 0, 0);
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        set_in(1, 0, 0, 0, 0);
        step();
        chk("R1", 0, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_normal();
        do_reset();
        set_in(1, 0, 0, 0, 0); step(); chk("R2", 1, 0);
        set_in(0, 0, 0, 0, 0); step(); chk("R2", 0, 1);
        set_in(1, 0, 0, 0, 1); step(); chk("R2", 1, 0);
        set_in(0, 1, 0, 0, 0); step(); chk("R7", 0, 1); // skip without tick ignored
        set_in(1, 1, 0, 0, 0); step(); chk("R7", 1, 0);
    endtask

    task automatic t_brake();
        do_reset();
        set_in(1, 1, 0, 0, 1); step(); chk("R7", 0, 0);
        set_in(1, 1, 0, 0, 0); step(); chk("R9", 0, 0);
        set_in(0, 1, 0, 0, 1); step(); chk("R9", 0, 0);
        set_in(1, 0, 0, 0, 0); step(); chk("R9", 0, 0); // no tick yet
        set_in(1, 0, 0, 0, 1); step(); chk("R9", 1, 0);
        set_in(0, 0, 0, 0, 0); step(); chk("R9", 0, 1);
    endtask

    task automatic t_prebias();
        do_reset();
        set_in(0, 1, 0, 1, 1); step(); chk("R8", 0, 1);
        set_in(1, 1, 0, 1, 1); step(); chk("R8", 1, 0);
        set_in(0, 1, 0, 0, 1); step(); chk("R7", 0, 0);
        set_in(0, 1, 0, 1, 0); step(); chk("R8", 0, 1);
    endtask

    task automatic t_ovp();
        do_reset();
        set_in(1, 0, 1, 0, 0); step(); chk("R3", 0, 1);
        set_in(0, 0, 1, 0, 1); step(); chk("R4", 0, 1);
        set_in(1, 1, 1, 0, 1); step(); chk("R4", 0, 1);
        set_in(1, 0, 0, 0, 0); step(); chk("R4", 0, 0);
        set_in(1, 0, 0, 0, 1); step(); chk("R5", 0, 0);
        set_in(0, 0, 0, 0, 1); step(); chk("R5", 0, 0);
        set_in(1, 1, 0, 1, 1); step(); chk("R5", 0, 0);
        set_in(1, 0, 1, 0, 0); step(); chk("R6", 0, 1);
        set_in(1, 0, 0, 0, 0); step(); chk("R4", 0, 0);
        // R12: reset leaves hold and normal drive returns
        rst_n = 1'b0; step(); chk("R12", 0, 0);
        rst_n = 1'b1;
        set_in(1, 0, 0, 0, 0); step(); chk("R12", 1, 0);
    endtask

    task automatic t_priority();
        do_reset();
        set_in(0, 1, 0, 0, 1); step(); chk("R7", 0, 0);
        set_in(1, 1, 1, 0, 1); step(); chk("R10", 0, 1);
        do_reset();
        set_in(1, 1, 1, 0, 1); step(); chk("R10", 0, 1);
        set_in(1, 1, 0, 0, 1); step(); chk("R10", 0, 0);
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1;
        t_reset();
        t_normal();
        t_brake();
        t_prebias();
        t_ovp();
        t_priority();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule